// File: doc/BRIEF.md
# First-Come Shared Bus Arbiter

This block stands in for an internal bus that several logic-block agents drive in common. It is built as a multiplexer with an arbiter instead of real tristate wires. Every agent presents a full-width data word and one enable for each 9-bit lane. A lane carries a byte and its parity bit, and the block passes both through unchanged. Lanes are gathered into groups of one, two or four lanes, that is 9, 18 or 36 lines. Each group is arbitrated on its own, and the grouping is fixed while reset is held.

An agent that claims an idle group keeps it for as long as it holds any enable inside that group, whatever the other agents request. When a group is dropped it stays unowned for one cycle before the next claim is granted. Lanes that are not driven keep their last value. Outputs are the resolved bus, a busy flag and an owner index per group, and a one-cycle blocked pulse per agent whose request was refused.

Top module: `fcfs_shared_bus`

## Requirements
- R1: While reset is held and on the first cycle after it, every group reads busy 0 and owner 0, the bus reads all zeros and no blocked bit is set.
- R2: The grouping code in cfg_mode is read as follows: 0 gives one lane per group (12 groups), 1 gives two lanes per group (6 groups), and 2 or 3 gives four lanes per group (3 groups). Group g covers lanes g*span to g*span+span-1. Lane l is bus_out[9l+8:9l]. The enable for agent a on lane l is agent_en[a*12+l], and the data for agent a on lane l is agent_data[(a*12+l)*9 +: 9]. An agent requests a group when any of its enables inside that group is 1.
- R3: When an idle group that is not in turnaround receives requests, the requester with the lowest index becomes owner on the clock edge that samples the request.
- R4: An owner keeps its group, with owner unchanged, on every edge where it still requests the group, even if a lower-index agent requests it.
- R5: On each edge where a group is owned after the update, every lane of that group whose enable is set by the owner loads the owner's data for that lane. The owner's other lanes and all other agents' data are ignored.
- R6: A lane that is not loaded under R5 keeps its previous value.
- R7: When the owner drops all of its enables in a group, the group reads busy 0 and owner 0 for exactly one cycle in which no claim is granted. A claim can win on the following edge.
- R8: blocked[a] is 1 for the cycle after an edge on which agent a requested a group that, after that edge, is owned by a different agent. It is not set in a turnaround cycle.
- R9: cfg_mode is taken only on edges with reset held, and changing it later has no effect on the grouping.
- R10: Group indices at or above the group count of the active mode always read busy 0 and owner 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads cfg_mode |
| cfg_mode | input | 2 | Grouping code (see R2) |
| agent_en | input | 48 | Per-agent, per-lane drive enables |
| agent_data | input | 432 | Per-agent, per-lane 9-bit data |
| bus_out | output | 108 | Resolved bus value |
| grp_busy | output | 12 | Group has an owner |
| grp_owner | output | 24 | Owner index, 2 bits per group, 0 when idle |
| blocked | output | 4 | Per-agent refused-request pulse |

## Verification
A table-driven sequence in the single-lane grouping runs two groups side by side. It covers simultaneous claims (this separates lowest-index choice from arrival order), a late lower-index request against a standing owner (non-preemption), and back-to-back release and reclaim (turnaround length). Fresh data on every step separates held lanes from reloaded ones. Directed runs in the two-lane and four-lane groupings enable only part of a group. They check that a non-owner's lane stays frozen and that a lane maps to the right group. After reset in the widest grouping, the mode input is switched. A shared claim that should stay a single group then shows whether that change was ignored.

// File: rtl/fcfs_bus_pkg.sv
package fcfs_bus_pkg;

    // log2 of lanes per group for a grouping code
    function automatic int unsigned span_log2(input logic [1:0] mode);
        case (mode)
            2'd0:    return 0;
            2'd1:    return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/fcfs_req_map.sv
module fcfs_req_map
    import fcfs_bus_pkg::*;
#(
    parameter int N_AG  = 4,
    parameter int LANES = 12
) (
    input  logic [1:0]            mode_q,
    input  logic [N_AG*LANES-1:0] lane_en,
    output logic [LANES*N_AG-1:0] grp_req
);
    // Group g, agent a is at bit g*N_AG+a. Groups beyond the count stay 0.
    always_comb begin
        int unsigned sh;
        sh = span_log2(mode_q);
        grp_req = '0;
        for (int a = 0; a < N_AG; a++) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_en[a*LANES+l]) begin
                    grp_req[(l >> sh)*N_AG + a] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fcfs_group_arb.sv
module fcfs_group_arb #(
    parameter int N_AG = 4,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_AG-1:0] req,
    output logic            busy_q,
    output logic [IDXW-1:0] owner_q,
    output logic            busy_nx,
    output logic [IDXW-1:0] owner_nx
);
    typedef struct packed {
        logic            busy;
        logic            turn;
        logic [IDXW-1:0] owner;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (!req[st_q.owner]) begin
                st_d.busy  = 1'b0;
                st_d.turn  = 1'b1;
                st_d.owner = '0;
            end
        end else if (st_q.turn) begin
            st_d.turn = 1'b0;
        end else if (|req) begin
            st_d.busy = 1'b1;
            for (int a = N_AG - 1; a >= 0; a--) begin
                if (req[a]) st_d.owner = IDXW'(a);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_q   = st_q.busy;
    assign owner_q  = st_q.owner;
    assign busy_nx  = st_d.busy;
    assign owner_nx = st_d.owner;

    // checking aid: requests seen on the previous edge
    logic [N_AG-1:0] req_p;
    always_ff @(posedge clk) begin
        req_p <= req;
    end

    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> req_p[owner_q] &&
            ((req_p & ((N_AG'(1) << owner_q) - N_AG'(1))) == '0));

    a_r4_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && req[owner_q] |=> busy_q && $stable(owner_q));

    a_r7_one_idle_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |=> !busy_q);

    a_r7_idle_owner_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> owner_q == '0);
endmodule

// File: rtl/fcfs_lane_hold.sv
module fcfs_lane_hold
    import fcfs_bus_pkg::*;
#(
    parameter int N_AG  = 4,
    parameter int LANES = 12,
    parameter int LW    = 9,
    parameter int IDXW  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_q,
    input  logic [LANES-1:0]         gnt_busy,
    input  logic [LANES*IDXW-1:0]    gnt_owner,
    input  logic [N_AG*LANES-1:0]    lane_en,
    input  logic [N_AG*LANES*LW-1:0] lane_data,
    output logic [LANES*LW-1:0]      bus_q
);
    logic [LANES*LW-1:0] bus_d;

    always_comb begin
        int unsigned sh;
        int          g;
        int          o;
        sh    = span_log2(mode_q);
        bus_d = bus_q;
        for (int l = 0; l < LANES; l++) begin
            g = int'(l >> sh);
            o = int'(gnt_owner[g*IDXW +: IDXW]);
            if (gnt_busy[g] && lane_en[o*LANES+l]) begin
                bus_d[l*LW +: LW] = lane_data[(o*LANES+l)*LW +: LW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    // checking aid: any agent enabling each lane
    logic [LANES-1:0] any_en;
    always_comb begin
        any_en = '0;
        for (int a = 0; a < N_AG; a++) begin
            any_en = any_en | lane_en[a*LANES +: LANES];
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_hold_chk
        a_r6_undriven_lane_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !any_en[l] |=> $stable(bus_q[l*LW +: LW]));
    end
endmodule

// File: rtl/fcfs_shared_bus.sv
module fcfs_shared_bus
    import fcfs_bus_pkg::*;
#(
    parameter int N_AG  = 4,
    parameter int LANES = 12,
    parameter int LW    = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cfg_mode,
    input  logic [N_AG*LANES-1:0]    agent_en,
    input  logic [N_AG*LANES*LW-1:0] agent_data,
    output logic [LANES*LW-1:0]      bus_out,
    output logic [LANES-1:0]         grp_busy,
    output logic [LANES*IDXW-1:0]    grp_owner,
    output logic [N_AG-1:0]          blocked
);
    localparam int IDXW   = (N_AG > 1) ? $clog2(N_AG) : 1;
    localparam int GROUPS = LANES;

    typedef struct packed {
        logic [1:0]      mode;
        logic [N_AG-1:0] blocked;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [GROUPS*N_AG-1:0] grp_req;
    logic [GROUPS-1:0]      busy_nx;
    logic [GROUPS*IDXW-1:0] owner_nx;

    fcfs_req_map #(.N_AG(N_AG), .LANES(LANES)) u_map (
        .mode_q  (st_q.mode),
        .lane_en (agent_en),
        .grp_req (grp_req)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_arb
        fcfs_group_arb #(.N_AG(N_AG), .IDXW(IDXW)) u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (grp_req[g*N_AG +: N_AG]),
            .busy_q   (grp_busy[g]),
            .owner_q  (grp_owner[g*IDXW +: IDXW]),
            .busy_nx  (busy_nx[g]),
            .owner_nx (owner_nx[g*IDXW +: IDXW])
        );
    end

    fcfs_lane_hold #(.N_AG(N_AG), .LANES(LANES), .LW(LW), .IDXW(IDXW)) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_q    (st_q.mode),
        .gnt_busy  (busy_nx),
        .gnt_owner (owner_nx),
        .lane_en   (agent_en),
        .lane_data (agent_data),
        .bus_q     (bus_out)
    );

    always_comb begin
        st_d         = st_q;
        st_d.blocked = '0;
        for (int g = 0; g < GROUPS; g++) begin
            for (int a = 0; a < N_AG; a++) begin
                if (grp_req[g*N_AG+a] && busy_nx[g] &&
                    owner_nx[g*IDXW +: IDXW] != IDXW'(a)) begin
                    st_d.blocked[a] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode    <= cfg_mode;
            st_q.blocked <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blocked = st_q.blocked;

    // checking aid: some group currently held by another agent
    logic [N_AG-1:0] other_owned;
    always_comb begin
        other_owned = '0;
        for (int g = 0; g < GROUPS; g++) begin
            for (int a = 0; a < N_AG; a++) begin
                if (grp_busy[g] && grp_owner[g*IDXW +: IDXW] != IDXW'(a)) other_owned[a] = 1'b1;
            end
        end
    end

    for (genvar a = 0; a < N_AG; a++) begin : g_blk_chk
        a_r8_blocked_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            blocked[a] |-> other_owned[a]);
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_dead_chk
        a_r10_unused_group_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (g >= (LANES >> span_log2(st_q.mode))) |-> !grp_busy[g]);
    end

    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(st_q.mode));
endmodule

// File: tb/fcfs_shared_bus_test.sv
module fcfs_shared_bus_test;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;
    localparam int NL = 12;
    localparam int WL = 9;
    localparam int NV = 11;

    // {mask lane0[4], mask lane1[4], busy0, owner0[2], busy1, owner1[2], blocked[4]}
    localparam logic [17:0] VEC [NV] = '{
        {4'b0011, 4'b0000, 1'b1, 2'd0, 1'b0, 2'd0, 4'b0010},
        {4'b0011, 4'b1000, 1'b1, 2'd0, 1'b1, 2'd3, 4'b0010},
        {4'b0010, 4'b1100, 1'b0, 2'd0, 1'b1, 2'd3, 4'b0100},
        {4'b0010, 4'b0100, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000},
        {4'b0010, 4'b0100, 1'b1, 2'd1, 1'b0, 2'd0, 4'b0000},
        {4'b0011, 4'b0100, 1'b1, 2'd1, 1'b1, 2'd2, 4'b0001},
        {4'b0000, 4'b0100, 1'b0, 2'd0, 1'b1, 2'd2, 4'b0000},
        {4'b1000, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000},
        {4'b1000, 4'b0001, 1'b1, 2'd3, 1'b0, 2'd0, 4'b0000},
        {4'b1000, 4'b0011, 1'b1, 2'd3, 1'b1, 2'd0, 4'b0010},
        {4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0, 4'b0000}
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [1:0]            cfg_mode = 2'd0;
    logic [NA*NL-1:0]      agent_en = '0;
    logic [NA*NL*WL-1:0]   agent_data = '0;
    logic [NL*WL-1:0]      bus_out;
    logic [NL-1:0]         grp_busy;
    logic [NL*2-1:0]       grp_owner;
    logic [NA-1:0]         blocked;

    int total = 0;
    int bad   = 0;

    fcfs_shared_bus uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode   (cfg_mode),
        .agent_en   (agent_en),
        .agent_data (agent_data),
        .bus_out    (bus_out),
        .grp_busy   (grp_busy),
        .grp_owner  (grp_owner),
        .blocked    (blocked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [WL-1:0] dval(input int a, input int l, input int seed);
        return WL'(a*37 + l*11 + seed);
    endfunction

    function automatic logic [NA*NL*WL-1:0] fill(input int seed);
        logic [NA*NL*WL-1:0] v;
        for (int a = 0; a < NA; a++)
            for (int l = 0; l < NL; l++)
                v[(a*NL+l)*WL +: WL] = dval(a, l, seed);
        return v;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n    = 1'b0;
        cfg_mode = m;
        agent_en = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic [NA*NL-1:0] en, input int seed);
        agent_en   = en;
        agent_data = fill(seed);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NL*WL-1:0] exp_bus;
        logic [NA*NL-1:0] en;

        // R1: reset state
        do_reset(2'd0);
        check("R1 busy",    128'(grp_busy),  '0);
        check("R1 owner",   128'(grp_owner), '0);
        check("R1 bus",     128'(bus_out),   '0);
        check("R1 blocked", 128'(blocked),   '0);

        // Table walk, one lane per group (R3 R4 R5 R6 R7 R8)
        exp_bus = '0;
        for (int i = 0; i < NV; i++) begin
            logic [3:0] m0, m1, eblk;
            logic       eb0, eb1;
            logic [1:0] eo0, eo1;
            logic [NL-1:0]   ebusy;
            logic [NL*2-1:0] eown;
            int seed;
            {m0, m1, eb0, eo0, eb1, eo1, eblk} = VEC[i];
            seed = i*16 + 5;
            en = '0;
            for (int a = 0; a < NA; a++) begin
                en[a*NL+0] = m0[a];
                en[a*NL+1] = m1[a];
            end
            step(en, seed);
            ebusy = '0; ebusy[0] = eb0; ebusy[1] = eb1;
            eown  = '0; eown[1:0] = eo0; eown[3:2] = eo1;
            if (eb0) exp_bus[0*WL +: WL] = dval(int'(eo0), 0, seed);
            if (eb1) exp_bus[1*WL +: WL] = dval(int'(eo1), 1, seed);
            check($sformatf("R3 R4 R7 busy step %0d", i), 128'(grp_busy), 128'(ebusy));
            check($sformatf("R3 R4 R7 owner step %0d", i), 128'(grp_owner), 128'(eown));
            check($sformatf("R8 blocked step %0d", i), 128'(blocked), 128'(eblk));
            check($sformatf("R5 R6 bus step %0d", i), 128'(bus_out), 128'(exp_bus));
        end

        // R2: two lanes per group; agent2 on lane3 takes group 1
        do_reset(2'd1);
        en = '0; en[2*NL+3] = 1'b1;
        step(en, 200);
        exp_bus = '0; exp_bus[3*WL +: WL] = dval(2, 3, 200);
        check("R2 R10 mode1 busy", 128'(grp_busy), 128'(12'h002));
        check("R2 mode1 owner", 128'(grp_owner), 128'(24'h8));
        check("R5 mode1 bus", 128'(bus_out), 128'(exp_bus));
        // agent1 on lane2 of the same group is refused, lane2 not loaded
        en[1*NL+2] = 1'b1;
        step(en, 201);
        exp_bus[3*WL +: WL] = dval(2, 3, 201);
        check("R8 mode1 blocked", 128'(blocked), 128'(4'b0010));
        check("R5 R6 mode1 bus", 128'(bus_out), 128'(exp_bus));

        // R2 R9: code 3 = four lanes per group; mode input changed after reset
        do_reset(2'd3);
        cfg_mode = 2'd0;
        en = '0; en[3*NL+7] = 1'b1;
        step(en, 210);
        exp_bus = '0; exp_bus[7*WL +: WL] = dval(3, 7, 210);
        check("R2 R10 mode3 busy", 128'(grp_busy), 128'(12'h002));
        check("R2 mode3 owner", 128'(grp_owner), 128'(24'hC));
        en[0*NL+4] = 1'b1;
        step(en, 211);
        exp_bus[7*WL +: WL] = dval(3, 7, 211);
        check("R9 mode held busy", 128'(grp_busy), 128'(12'h002));
        check("R9 R8 mode held blocked", 128'(blocked), 128'(4'b0001));
        check("R6 R9 mode held bus", 128'(bus_out), 128'(exp_bus));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule